// File: doc/BRIEF.md
# Two-Deep Read Return Tracker

This block sits beside a processor's system-bus read path and works out which outstanding read each returning data beat belongs to. Reads are recorded as they are issued, each with a caller-chosen tag and a flag that says whether it fetches instructions or data. At most two reads may be pending. Responses are expected in issue order unless the external agent signals otherwise. The agent does this by pulling an active-low swap strobe low, and every cycle the strobe is held low flips the expected order. The bus carries no tag of its own.

Each response is a fixed burst of data beats, marked by an active-low valid strobe. For every beat the tracker reports the tag and kind of the read being filled. On the final beat of a burst it raises a done pulse and retires that read, and the survivor becomes the head. The swap strobe must lead the data by a minimum number of cycles. A swap that comes too late, or that arrives with fewer than two reads pending, sets a sticky error flag.

Top module: `rd_return_tracker`

## Requirements
- R1: After synchronous reset both slots are empty, `rd_ready` is 1, and `beat_vld`, `done` and `swap_err` are 0.
- R2: While two reads are pending `rd_ready` is 0, and an issue presented then is not recorded: its tag never appears on `beat_tag`.
- R3: With no swap, responses are attributed to the reads in the order they were issued.
- R4: Each clock cycle in which `swap_n` is 0 while two reads are pending flips the expected order. One such cycle makes the newer read return first. Two such cycles restore issue order.
- R5: A beat sampled with `data_valid_n` = 0 at a clock edge appears on `beat_vld` = 1 right after that edge, together with the tag of the read being filled and its kind (`beat_instr` = 1 for an instruction read, 0 for a data read, as given on `rd_instr` at issue).
- R6: A response is BEATS beats long (default 4). `done` is 1 together with the last beat's `beat_vld`. That read is retired at the same edge, so `rd_ready` is 1 again right after it, and the remaining read becomes the head in issue order.
- R7: A data beat sampled in the same cycle as a swap, or fewer than GAP_MIN (default 2) cycles after the last swap cycle, sets `swap_err`. A swap followed by GAP_MIN or more idle cycles does not set it.
- R8: A swap cycle while fewer than two reads are pending sets `swap_err` and changes no order.
- R9: Once set, `swap_err` stays 1 until reset.
- R10: A data beat while no read is pending produces no `beat_vld`.
- R11: With one read pending, a read issued in the cycle of that read's last beat is accepted and served by the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_issue | input | 1 | A read is being issued this cycle |
| rd_tag | input | TAG_W | Tag of the issued read |
| rd_instr | input | 1 | 1 = instruction read, 0 = data read |
| rd_ready | output | 1 | A new read can be recorded this cycle |
| swap_n | input | 1 | Active-low order-swap strobe |
| data_valid_n | input | 1 | Active-low data beat strobe |
| beat_vld | output | 1 | A beat was attributed on the previous edge |
| beat_tag | output | TAG_W | Tag of the read the beat belongs to |
| beat_instr | output | 1 | Kind of that read |
| done | output | 1 | Last beat of a response; the read is retired |
| swap_err | output | 1 | Sticky swap-timing or swap-context error |

## Verification
Beat attribution, `done` and `swap_err` are registered, so each one is due exactly one edge after the beat or swap that causes it. `rd_ready` follows the slot state at that same edge. The driver pushes one expected tag, kind and last-flag per beat before it drives the beat. A monitor pops the queue on the falling edge after each `beat_vld`, so every comparison lands half a cycle after the result has settled. Direct checks of `rd_ready` and `swap_err` are taken just after the edge that should have changed them. Swap strobes are followed by exactly the idle cycles the spacing rule asks for, or by deliberately fewer.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    parameter int DEF_TAG_W = 4;
    parameter int DEF_BEATS = 4;
    parameter int DEF_GAP   = 2;

    typedef enum logic {
        KIND_DATA  = 1'b0,
        KIND_INSTR = 1'b1
    } rd_kind_e;

    function automatic rd_kind_e kind_of(input logic instr_bit);
        return instr_bit ? KIND_INSTR : KIND_DATA;
    endfunction

    // A beat is too close to a swap if the swap is in the same cycle or the
    // cycles elapsed since it are below the required lead.
    function automatic logic swap_too_late(input int since, input int lead, input logic swap_now);
        return swap_now || (since < lead - 1);
    endfunction

endpackage

// File: rtl/rrt_queue.sv
module rrt_queue
    import rrt_pkg::*;
#(
    parameter int TAG_W = DEF_TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             push_instr,
    input  logic             pop,
    input  logic             pop_idx,
    input  logic             flip,
    input  logic             sel_idx,
    output logic             full,
    output logic [1:0]       occ,
    output logic             head_idx,
    output logic [TAG_W-1:0] sel_tag,
    output rd_kind_e         sel_kind
);

    localparam int SLOTS = 2;

    typedef struct packed {
        logic             vld;
        rd_kind_e         kind;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t slot_q [SLOTS];
    slot_t slot_d [SLOTS];
    logic  rev_q, rev_d;
    slot_t fresh;

    assign full     = slot_q[0].vld & slot_q[1].vld;
    assign occ      = {1'b0, slot_q[0].vld} + {1'b0, slot_q[1].vld};
    assign head_idx = rev_q & slot_q[1].vld;
    assign sel_tag  = slot_q[sel_idx].tag;
    assign sel_kind = slot_q[sel_idx].kind;

    always_comb begin
        fresh.vld  = 1'b1;
        fresh.kind = kind_of(push_instr);
        fresh.tag  = push_tag;
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) slot_d[i] = slot_q[i];
        rev_d = rev_q;
        if (flip && full) rev_d = ~rev_q;
        if (pop) begin
            if (!pop_idx) slot_d[0] = slot_q[1];
            slot_d[1] = '0;
            rev_d     = 1'b0;
        end
        if (push && !full) begin
            if (!slot_d[0].vld) slot_d[0] = fresh;
            else                slot_d[1] = fresh;
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) slot_q[g] <= '0;
                else     slot_q[g] <= slot_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) rev_q <= 1'b0;
        else     rev_q <= rev_d;
    end

endmodule

// File: rtl/rrt_swap_mon.sv
module rrt_swap_mon
    import rrt_pkg::*;
#(
    parameter int GAP_MIN = DEF_GAP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       swap_act,
    input  logic       beat_act,
    input  logic [1:0] occ,
    output logic       err
);

    localparam int GW   = (GAP_MIN > 1) ? $clog2(GAP_MIN) : 1;
    localparam int GMAX = (GAP_MIN > 1) ? GAP_MIN - 1 : 0;

    logic [GW-1:0] since_q;
    logic          late, lonely;

    assign late   = beat_act && swap_too_late(int'(since_q), GAP_MIN, swap_act);
    assign lonely = swap_act && (occ < 2'd2);

    always_ff @(posedge clk) begin
        if (rst)                        since_q <= GW'(GMAX);
        else if (swap_act)              since_q <= '0;
        else if (int'(since_q) < GMAX)  since_q <= since_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= err | late | lonely;
    end

endmodule

// File: rtl/rrt_beat_ctr.sv
module rrt_beat_ctr
    import rrt_pkg::*;
#(
    parameter int BEATS = DEF_BEATS
) (
    input  logic clk,
    input  logic rst,
    input  logic beat,
    input  logic head_idx,
    output logic cur_idx,
    output logic last
);

    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CW-1:0] cnt_q;
    logic          lock_q;
    logic          busy;

    assign busy    = (cnt_q != '0);
    assign cur_idx = busy ? lock_q : head_idx;
    assign last    = (int'(cnt_q) == BEATS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (beat) begin
            if (!busy) lock_q <= head_idx;
            if (last)  cnt_q  <= '0;
            else       cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rd_return_tracker.sv
module rd_return_tracker
    import rrt_pkg::*;
#(
    parameter int TAG_W   = DEF_TAG_W,
    parameter int BEATS   = DEF_BEATS,
    parameter int GAP_MIN = DEF_GAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_issue,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             rd_instr,
    output logic             rd_ready,
    input  logic             swap_n,
    input  logic             data_valid_n,
    output logic             beat_vld,
    output logic [TAG_W-1:0] beat_tag,
    output logic             beat_instr,
    output logic             done,
    output logic             swap_err
);

    logic             swap_act, beat_raw, beat_ok;
    logic             full, head_idx, cur_idx, last, pop;
    logic [1:0]       occ;
    logic [TAG_W-1:0] sel_tag;
    rd_kind_e         sel_kind;

    assign swap_act = ~swap_n;
    assign beat_raw = ~data_valid_n;
    assign beat_ok  = beat_raw && (occ != 2'd0);
    assign pop      = beat_ok && last;
    assign rd_ready = ~full;

    rrt_queue #(.TAG_W(TAG_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (rd_issue),
        .push_tag  (rd_tag),
        .push_instr(rd_instr),
        .pop       (pop),
        .pop_idx   (cur_idx),
        .flip      (swap_act),
        .sel_idx   (cur_idx),
        .full      (full),
        .occ       (occ),
        .head_idx  (head_idx),
        .sel_tag   (sel_tag),
        .sel_kind  (sel_kind)
    );

    rrt_beat_ctr #(.BEATS(BEATS)) u_beats (
        .clk     (clk),
        .rst     (rst),
        .beat    (beat_ok),
        .head_idx(head_idx),
        .cur_idx (cur_idx),
        .last    (last)
    );

    rrt_swap_mon #(.GAP_MIN(GAP_MIN)) u_swap (
        .clk     (clk),
        .rst     (rst),
        .swap_act(swap_act),
        .beat_act(beat_raw),
        .occ     (occ),
        .err     (swap_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_vld   <= 1'b0;
            beat_tag   <= '0;
            beat_instr <= 1'b0;
            done       <= 1'b0;
        end else begin
            beat_vld   <= beat_ok;
            beat_tag   <= beat_ok ? sel_tag : beat_tag;
            beat_instr <= beat_ok ? (sel_kind == KIND_INSTR) : beat_instr;
            done       <= pop;
        end
    end

endmodule

// File: rtl/rrt_tracker_chk.sv
module rrt_tracker_chk (
    input logic clk,
    input logic rst,
    input logic rd_issue,
    input logic rd_ready,
    input logic swap_n,
    input logic data_valid_n,
    input logic beat_vld,
    input logic done,
    input logic swap_err
);

    logic [2:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_q + 3'(rd_issue && rd_ready) - 3'(done);
    end

    // R2: accepted reads never exceed two in flight
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        pend_q <= 3'd2);

    // R5: a beat report follows a sampled data beat
    p_beat_latency_r5: assert property (@(posedge clk) disable iff (rst)
        beat_vld |-> $past(!data_valid_n));

    // R6: done only accompanies a beat report
    p_done_with_beat_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> beat_vld);

    // R7: a beat in the swap cycle always flags an error
    p_late_swap_r7: assert property (@(posedge clk) disable iff (rst)
        (!swap_n && !data_valid_n) |=> swap_err);

    // R9: the error flag holds until reset
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        swap_err |=> swap_err);

endmodule

bind rd_return_tracker rrt_tracker_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .rd_issue    (rd_issue),
    .rd_ready    (rd_ready),
    .swap_n      (swap_n),
    .data_valid_n(data_valid_n),
    .beat_vld    (beat_vld),
    .done        (done),
    .swap_err    (swap_err)
);

// File: tb/rd_return_tracker_tb_top.sv
module rd_return_tracker_tb_top;

    localparam int TAG_W = 4;
    localparam int BEATS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rd_issue = 1'b0;
    logic [TAG_W-1:0] rd_tag = '0;
    logic             rd_instr = 1'b0;
    logic             rd_ready;
    logic             swap_n = 1'b1;
    logic             data_valid_n = 1'b1;
    logic             beat_vld;
    logic [TAG_W-1:0] beat_tag;
    logic             beat_instr;
    logic             done;
    logic             swap_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic [TAG_W-1:0] tag;
        logic             instr;
        logic             last;
        string            req;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    rd_return_tracker #(.TAG_W(TAG_W), .BEATS(BEATS), .GAP_MIN(2)) dut_i (
        .clk(clk), .rst(rst), .rd_issue(rd_issue), .rd_tag(rd_tag),
        .rd_instr(rd_instr), .rd_ready(rd_ready), .swap_n(swap_n),
        .data_valid_n(data_valid_n), .beat_vld(beat_vld), .beat_tag(beat_tag),
        .beat_instr(beat_instr), .done(done), .swap_err(swap_err)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // monitor: compare each attributed beat with the scoreboard head
    always @(negedge clk) begin
        if (!rst && beat_vld) begin
            if (sbq.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R2/R10 unexpected beat: actual tag %0d expected none", beat_tag);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.req, " tag"},   int'(beat_tag),   int'(e.tag));
                chk({e.req, " kind"},  int'(beat_instr), int'(e.instr));
                chk({e.req, " done"},  int'(done),       int'(e.last));
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    task automatic issue(input logic [TAG_W-1:0] t, input logic ins);
        rd_issue = 1'b1;
        rd_tag   = t;
        rd_instr = ins;
        tick();
        rd_issue = 1'b0;
    endtask

    task automatic send_resp(input logic [TAG_W-1:0] t, input logic ins, input string req);
        for (int b = 0; b < BEATS; b++) begin
            exp_t e;
            e.tag = t; e.instr = ins; e.last = (b == BEATS - 1); e.req = req;
            sbq.push_back(e);
            data_valid_n = 1'b0;
            tick();
        end
        data_valid_n = 1'b1;
    endtask

    task automatic swap_pulse(input int cycles);
        swap_n = 1'b0;
        repeat (cycles) tick();
        swap_n = 1'b1;
        tick();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ready", int'(rd_ready), 1);
        chk("R1 beat_vld", int'(beat_vld), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 swap_err", int'(swap_err), 0);

        // R10 beat with nothing pending
        data_valid_n = 1'b0;
        tick();
        data_valid_n = 1'b1;
        chk("R10 no beat", int'(beat_vld), 0);
        tick();

        // R2 / R3 / R5 / R6 in-order pair, refused third issue
        issue(4'd3, 1'b1);
        issue(4'd5, 1'b0);
        chk("R2 ready low when full", int'(rd_ready), 0);
        issue(4'd9, 1'b1);
        chk("R2 still full after refused issue", int'(rd_ready), 0);
        send_resp(4'd3, 1'b1, "R3/R5/R6 first in order");
        chk("R6 done on last beat", int'(done), 1);
        chk("R6 ready after retire", int'(rd_ready), 1);
        send_resp(4'd5, 1'b0, "R3/R6 survivor is head");
        issue(4'd12, 1'b0);
        send_resp(4'd12, 1'b0, "R2 refused tag absent");
        tick();

        // R4 single swap: newer first
        issue(4'd1, 1'b0);
        issue(4'd2, 1'b1);
        swap_pulse(1);
        send_resp(4'd2, 1'b1, "R4 single swap newer first");
        send_resp(4'd1, 1'b0, "R4 older follows");
        chk("R7 spaced swap no error", int'(swap_err), 0);

        // R4 double swap restores order
        issue(4'd6, 1'b1);
        issue(4'd7, 1'b0);
        swap_pulse(2);
        send_resp(4'd6, 1'b1, "R4 double swap in order");
        send_resp(4'd7, 1'b0, "R4 double swap second");
        chk("R7 double swap spaced no error", int'(swap_err), 0);

        // R11 issue in the last-beat cycle
        issue(4'd8, 1'b0);
        for (int b = 0; b < BEATS; b++) begin
            exp_t e;
            e.tag = 4'd8; e.instr = 1'b0; e.last = (b == BEATS - 1); e.req = "R11 first read";
            sbq.push_back(e);
            data_valid_n = 1'b0;
            if (b == BEATS - 1) begin
                rd_issue = 1'b1; rd_tag = 4'd10; rd_instr = 1'b1;
            end
            tick();
            rd_issue = 1'b0;
        end
        data_valid_n = 1'b1;
        chk("R11 ready with one pending", int'(rd_ready), 1);
        send_resp(4'd10, 1'b1, "R11 read issued at retire");
        tick();

        // R8 swap with one pending, R9 sticky
        issue(4'd4, 1'b0);
        swap_pulse(1);
        chk("R8 lonely swap error", int'(swap_err), 1);
        repeat (3) tick();
        chk("R9 error sticky", int'(swap_err), 1);
        do_reset();
        chk("R1 error cleared by reset", int'(swap_err), 0);
        chk("R1 slots cleared by reset", int'(rd_ready), 1);

        // R7 beat one cycle after swap
        issue(4'd1, 1'b0);
        issue(4'd2, 1'b1);
        swap_n = 1'b0;
        tick();
        swap_n = 1'b1;
        begin
            exp_t e;
            e.tag = 4'd2; e.instr = 1'b1; e.last = 1'b0; e.req = "R7 late beat attribution";
            sbq.push_back(e);
        end
        data_valid_n = 1'b0;
        tick();
        data_valid_n = 1'b1;
        chk("R7 late swap error", int'(swap_err), 1);
        tick();
        do_reset();

        repeat (2) tick();
        chk("scoreboard drained", sbq.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule